// File: doc/BRIEF.md
# Fracturable Six-Input Lookup Cell

A configurable logic cell holding a 64-entry truth table. Six logic inputs address the table. The cell drives two outputs: a full output and a half output. In single-function mode the full output is any function of all six inputs, and the half output is idle. In dual mode the table is read as two five-input functions that share inputs 1 to 5. The half output reads the lower half of the table. The full output still uses input 6, so system logic holds input 6 high and the full output then reads the upper half.

Each output can be taken straight from the table or through its own flip-flop. Each flip-flop has a clock enable and a shared set/reset line. Per output, attributes choose whether that line sets or clears the flip-flop, whether it acts at the clock edge or at once, and what value the flip-flop takes on configuration. A load strobe writes the table, the mode and both attribute sets in one clock.

Top module: `lut6_frac_cell`

## Requirements
- R1: After the synchronous reset the table is all zeros, the cell is in single mode and all attributes are zero, so both outputs are 0 for every input pattern.
- R2: In single mode (`cfg_dual`=0) `full_out` is table bit `lut_in` (input 1 is bit 0, input 6 is bit 5), and with an unregistered half output `half_out` is 0.
- R3: In dual mode `half_out` is table bit `{0, lut_in[4:0]}`, whatever the value of input 6. `full_out` stays table bit `lut_in`, so with input 6 high it reads entries 32 to 63.
- R4: A clock edge with `cfg_load`=1 captures the table, mode and both attribute words. They take effect from that edge on.
- R5: An attribute word is 4 bits: bit0 picks the registered output, bit1 makes the set/reset line set (1) or clear (0), bit2 makes it act immediately (1) or at the edge (0), and bit3 is the configured value. With bit0 set, the output shows the flip-flop. The flip-flop takes the table value at an edge with `ce`=1 and holds it while `ce`=0.
- R6: With bit2 clear, `sr`=1 leaves the output unchanged until the next edge. At that edge the flip-flop takes the bit1 value, even with `ce`=0.
- R7: With bit2 set, `sr`=1 drives a registered output to the bit1 value in the same cycle, even with `ce`=0. The flip-flop also takes that value at the edge, so it persists after `sr` falls.
- R8: A configuration load sets each flip-flop to its bit3 value, whatever its bit1 setting. Reset clears it. Configuration load takes priority over `sr` and `ce`.
- R9: The two outputs use their own attribute words. Each flip-flop's mode, set/reset style and configured value do not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Configuration load strobe |
| cfg_table | input | 64 | Truth-table word, entry n at bit n |
| cfg_dual | input | 1 | 1 = two five-input functions |
| cfg_full_attr | input | 4 | Storage attributes of the full output |
| cfg_half_attr | input | 4 | Storage attributes of the half output |
| lut_in | input | 6 | Logic inputs, input 1 at bit 0 |
| ce | input | 1 | Flip-flop clock enable |
| sr | input | 1 | Shared set/reset line |
| full_out | output | 1 | Six-input (or upper-half) output |
| half_out | output | 1 | Lower-half five-input output |

## Verification
The bench sweeps every input pattern against several tables in both modes. An inverted address bit or a swapped half shows up as a wrong entry. A half output that follows input 6 fails the dual-mode sweep with input 6 at both levels. The flip-flop tests check that `ce` gates only captures. A set/reset that waits for `ce`, or that treats the edge and immediate styles the same, is caught by sampling before and after the edge. A configured value tied to the set/reset style is caught by pairing a clearing style with a configured 1.

// File: rtl/lutcell_pkg.sv
package lutcell_pkg;

    localparam int ATTR_W = 4;
    localparam int N_OUT  = 2;

    // index of each output in the storage array
    localparam int OUT_FULL = 0;
    localparam int OUT_HALF = 1;

    typedef struct packed {
        logic init_val;   // bit3: value taken on configuration
        logic sr_now;     // bit2: set/reset acts without waiting for an edge
        logic sr_set;     // bit1: set/reset drives 1 (else 0)
        logic use_reg;    // bit0: output taken from the flip-flop
    } stor_attr_t;

    function automatic logic sr_target(stor_attr_t a);
        return a.sr_set;
    endfunction

endpackage

// File: rtl/lutcell_cfg.sv
module lutcell_cfg
    import lutcell_pkg::*;
#(
    parameter int TBL_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [TBL_W-1:0] tbl_d,
    input  logic             dual_d,
    input  stor_attr_t       full_d,
    input  stor_attr_t       half_d,
    output logic [TBL_W-1:0] tbl_q,
    output logic             dual_q,
    output stor_attr_t       full_q,
    output stor_attr_t       half_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            tbl_q  <= '0;
            dual_q <= 1'b0;
            full_q <= '0;
            half_q <= '0;
        end else if (load) begin
            tbl_q  <= tbl_d;
            dual_q <= dual_d;
            full_q <= full_d;
            half_q <= half_d;
        end
    end

endmodule

// File: rtl/lutcell_lookup.sv
module lutcell_lookup #(
    parameter int IN_W  = 6,
    parameter int TBL_W = 1 << IN_W
) (
    input  logic [TBL_W-1:0] tbl,
    input  logic [IN_W-1:0]  sel,
    input  logic             dual,
    output logic             full_val,
    output logic             half_val
);

    logic [IN_W-1:0] lo_idx;

    always_comb begin
        lo_idx   = {1'b0, sel[IN_W-2:0]};
        full_val = tbl[sel];
        half_val = dual ? tbl[lo_idx] : 1'b0;
    end

endmodule

// File: rtl/lutcell_stor.sv
module lutcell_stor
    import lutcell_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic       load_init,
    input  stor_attr_t attr,
    input  logic       d,
    input  logic       ce,
    input  logic       sr,
    output logic       q,
    output logic       y
);

    logic sr_val;

    always_comb begin
        sr_val = sr_target(attr);
        if (!attr.use_reg)
            y = d;
        else if (attr.sr_now && sr)
            y = sr_val;
        else
            y = q;
    end

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else if (load)
            q <= load_init;
        else if (sr)
            q <= sr_val;
        else if (ce)
            q <= d;
    end

endmodule

// File: rtl/lut6_frac_cell.sv
module lut6_frac_cell
    import lutcell_pkg::*;
#(
    parameter  int IN_W  = 6,
    localparam int TBL_W = 1 << IN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_load,
    input  logic [TBL_W-1:0]  cfg_table,
    input  logic              cfg_dual,
    input  logic [ATTR_W-1:0] cfg_full_attr,
    input  logic [ATTR_W-1:0] cfg_half_attr,
    input  logic [IN_W-1:0]   lut_in,
    input  logic              ce,
    input  logic              sr,
    output logic              full_out,
    output logic              half_out
);

    logic [TBL_W-1:0] tbl_q;
    logic             dual_q;
    stor_attr_t       full_attr_q;
    stor_attr_t       half_attr_q;
    logic             full_val;
    logic             half_val;

    stor_attr_t       attr_arr  [N_OUT];
    stor_attr_t       ld_arr    [N_OUT];
    logic [N_OUT-1:0] d_vec;
    logic [N_OUT-1:0] q_vec;
    logic [N_OUT-1:0] y_vec;
    logic             q_full;
    logic             q_half;

    lutcell_cfg #(.TBL_W(TBL_W)) cfg_i (
        .clk    (clk),
        .rst    (rst),
        .load   (cfg_load),
        .tbl_d  (cfg_table),
        .dual_d (cfg_dual),
        .full_d (stor_attr_t'(cfg_full_attr)),
        .half_d (stor_attr_t'(cfg_half_attr)),
        .tbl_q  (tbl_q),
        .dual_q (dual_q),
        .full_q (full_attr_q),
        .half_q (half_attr_q)
    );

    lutcell_lookup #(.IN_W(IN_W), .TBL_W(TBL_W)) look_i (
        .tbl      (tbl_q),
        .sel      (lut_in),
        .dual     (dual_q),
        .full_val (full_val),
        .half_val (half_val)
    );

    always_comb begin
        attr_arr[OUT_FULL] = full_attr_q;
        attr_arr[OUT_HALF] = half_attr_q;
        ld_arr[OUT_FULL]   = stor_attr_t'(cfg_full_attr);
        ld_arr[OUT_HALF]   = stor_attr_t'(cfg_half_attr);
        d_vec[OUT_FULL]    = full_val;
        d_vec[OUT_HALF]    = half_val;
    end

    for (genvar g = 0; g < N_OUT; g++) begin : g_stor
        lutcell_stor stor_i (
            .clk       (clk),
            .rst       (rst),
            .load      (cfg_load),
            .load_init (ld_arr[g].init_val),
            .attr      (attr_arr[g]),
            .d         (d_vec[g]),
            .ce        (ce),
            .sr        (sr),
            .q         (q_vec[g]),
            .y         (y_vec[g])
        );
    end

    assign q_full   = q_vec[OUT_FULL];
    assign q_half   = q_vec[OUT_HALF];
    assign full_out = y_vec[OUT_FULL];
    assign half_out = y_vec[OUT_HALF];

endmodule

// File: rtl/lut6_frac_cell_chk.sv
module lut6_frac_cell_chk
    import lutcell_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cfg_load,
    input logic [ATTR_W-1:0] cfg_full_attr,
    input logic [ATTR_W-1:0] cfg_half_attr,
    input logic              ce,
    input logic              sr,
    input logic              full_out,
    input logic              half_out,
    input logic              dual_q,
    input stor_attr_t        full_attr_q,
    input stor_attr_t        half_attr_q,
    input logic              q_full,
    input logic              q_half
);

    // R2: single mode with an unregistered half output gives 0
    a_r2_half_idle: assert property (@(posedge clk) disable iff (rst)
        (!dual_q && !half_attr_q.use_reg) |-> (half_out == 1'b0));

    // R8: reset leaves both flip-flops cleared
    a_r8_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (q_full == 1'b0 && q_half == 1'b0));

    // R8: load sets each flip-flop to its own configured value
    a_r8_load_init: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(cfg_load)) |->
        (q_full == $past(cfg_full_attr[3]) && q_half == $past(cfg_half_attr[3])));

    // R6: an sr edge without a load puts the set/reset value into the flip-flop
    a_r6_sr_edge: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sr && !cfg_load)) |->
        (q_full == $past(full_attr_q.sr_set) && q_half == $past(half_attr_q.sr_set)));

    // R5: no enable, no sr, no load: the flip-flops hold
    a_r5_hold: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(!ce && !sr && !cfg_load)) |->
        ($stable(q_full) && $stable(q_half)));

    // R7: immediate set/reset overrides a registered output in the same cycle
    a_r7_now_full: assert property (@(posedge clk) disable iff (rst)
        (sr && full_attr_q.use_reg && full_attr_q.sr_now) |->
        (full_out == full_attr_q.sr_set));

    a_r7_now_half: assert property (@(posedge clk) disable iff (rst)
        (sr && half_attr_q.use_reg && half_attr_q.sr_now) |->
        (half_out == half_attr_q.sr_set));

endmodule

bind lut6_frac_cell lut6_frac_cell_chk chk_i (
    .clk           (clk),
    .rst           (rst),
    .cfg_load      (cfg_load),
    .cfg_full_attr (cfg_full_attr),
    .cfg_half_attr (cfg_half_attr),
    .ce            (ce),
    .sr            (sr),
    .full_out      (full_out),
    .half_out      (half_out),
    .dual_q        (dual_q),
    .full_attr_q   (full_attr_q),
    .half_attr_q   (half_attr_q),
    .q_full        (q_full),
    .q_half        (q_half)
);

// File: tb/lut6_frac_cell_tb_top.sv
module lut6_frac_cell_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_load = 1'b0;
    logic [63:0] cfg_table = '0;
    logic        cfg_dual = 1'b0;
    logic [3:0]  cfg_full_attr = '0;
    logic [3:0]  cfg_half_attr = '0;
    logic [5:0]  lut_in = '0;
    logic        ce = 1'b0;
    logic        sr = 1'b0;
    logic        full_out;
    logic        half_out;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // attribute bits: 0 registered, 1 sets, 2 immediate, 3 configured value
    localparam logic [3:0] A_REG = 4'b0001;
    localparam logic [3:0] A_SET = 4'b0010;
    localparam logic [3:0] A_NOW = 4'b0100;
    localparam logic [3:0] A_INI = 4'b1000;

    always #10 clk = ~clk;

    lut6_frac_cell dut_i (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_table(cfg_table),
        .cfg_dual(cfg_dual), .cfg_full_attr(cfg_full_attr),
        .cfg_half_attr(cfg_half_attr), .lut_in(lut_in), .ce(ce), .sr(sr),
        .full_out(full_out), .half_out(half_out)
    );

    task automatic check(string req, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b (lut_in=%0d)", req, got, exp, lut_in);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    task automatic load_cfg(logic [63:0] t, logic dual, logic [3:0] fa, logic [3:0] ha);
        @(negedge clk);
        cfg_table = t; cfg_dual = dual; cfg_full_attr = fa; cfg_half_attr = ha;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        #2;
    endtask

    function automatic logic bit_of(logic [63:0] t, int idx);
        return logic'((t >> idx) & 64'd1);
    endfunction

    initial begin
        #(20 * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [63:0] tabs [3];
        tabs[0] = 64'hF0E1_D2C3_B4A5_9687;
        tabs[1] = 64'h0123_4567_89AB_CDEF;
        tabs[2] = 64'hAAAA_5555_CCCC_3333;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        #2;
        // R1: reset state for every input pattern
        for (int i = 0; i < 64; i++) begin
            lut_in = 6'(i); #1;
            check("R1 full", full_out, 1'b0);
            check("R1 half", half_out, 1'b0);
        end

        // R2 / R4: single mode, exhaustive over inputs and tables
        for (int t = 0; t < 3; t++) begin
            load_cfg(tabs[t], 1'b0, 4'h0, 4'h0);
            for (int i = 0; i < 64; i++) begin
                lut_in = 6'(i); #1;
                check("R2 full", full_out, bit_of(tabs[t], i));
                check("R2 half", half_out, 1'b0);
            end
        end

        // R3: dual mode, half ignores input 6, full reads upper half when high
        for (int t = 0; t < 3; t++) begin
            load_cfg(tabs[t], 1'b1, 4'h0, 4'h0);
            for (int i = 0; i < 64; i++) begin
                lut_in = 6'(i); #1;
                check("R3 half", half_out, bit_of(tabs[t], i % 32));
                check("R3 full", full_out, bit_of(tabs[t], i));
            end
        end

        // R8 / R9: registered, clearing style with configured 1 on full; half configured 0
        load_cfg(tabs[0], 1'b1, A_REG | A_INI, A_REG | A_SET);
        check("R8 full init", full_out, 1'b1);
        check("R9 half init", half_out, 1'b0);

        // R5: capture with ce, hold without
        lut_in = 6'd33; ce = 1'b1;           // entry 33 and entry 1 of tabs[0]
        @(negedge clk); #2;
        check("R5 full capture", full_out, bit_of(tabs[0], 33));
        check("R5 half capture", half_out, bit_of(tabs[0], 1));
        ce = 1'b0;
        for (int i = 32; i < 64; i++) begin
            lut_in = 6'(i);
            @(negedge clk); #2;
            check("R5 full hold", full_out, bit_of(tabs[0], 33));
            check("R5 half hold", half_out, bit_of(tabs[0], 1));
        end
        // capture sweep with ce held
        ce = 1'b1;
        for (int i = 32; i < 64; i++) begin
            lut_in = 6'(i);
            @(negedge clk); #2;
            check("R5 full track", full_out, bit_of(tabs[0], i));
            check("R5 half track", half_out, bit_of(tabs[0], i - 32));
        end
        ce = 1'b0;

        // R6: edge style: full clears, half sets
        load_cfg(64'hFFFF_FFFF_0000_0000, 1'b1, A_REG | A_INI, A_REG | A_SET);
        lut_in = 6'd63;
        sr = 1'b1; #1;
        check("R6 full before edge", full_out, 1'b1);
        check("R6 half before edge", half_out, 1'b0);
        @(negedge clk); #2;
        check("R6 full after edge", full_out, 1'b0);
        check("R6 half after edge", half_out, 1'b1);
        sr = 1'b0; ce = 1'b1;
        @(negedge clk); #2;
        check("R6 full recapture", full_out, 1'b1);
        check("R6 half recapture", half_out, 1'b0);
        ce = 1'b0;

        // R7: immediate style on full (sets), edge style on half (clears)
        load_cfg(64'h0, 1'b1, A_REG | A_SET | A_NOW, A_REG | A_INI);
        check("R8 full init 0", full_out, 1'b0);
        check("R8 half init 1", half_out, 1'b1);
        sr = 1'b1; #1;
        check("R7 full immediate", full_out, 1'b1);
        check("R9 half waits edge", half_out, 1'b1);
        @(negedge clk);
        sr = 1'b0; #2;
        check("R7 full persists", full_out, 1'b1);
        check("R9 half cleared", half_out, 1'b0);

        // R8: load wins over sr and ce
        @(negedge clk);
        cfg_table = 64'hFFFF_FFFF_FFFF_FFFF; cfg_dual = 1'b1;
        cfg_full_attr = A_REG; cfg_half_attr = A_REG | A_INI;
        cfg_load = 1'b1; sr = 1'b1; ce = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0; sr = 1'b0; ce = 1'b0; #2;
        check("R8 full load priority", full_out, 1'b0);
        check("R8 half load priority", half_out, 1'b1);

        // R1: reset again clears registered state and configuration
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; #2;
        check("R1 full after reset", full_out, 1'b0);
        check("R1 half after reset", half_out, 1'b0);

        finish_run();
    end

endmodule